// File: doc/BRIEF.md
# Address-Translation Unit Configuration and Fault Register Bank

This block is the software-visible register bank of an I/O address translation unit. A processor reaches it through a simple word-wide register bus: one select strobe, a write flag, a byte address, write data and a combinational read data return. The bank holds the translator's control word, the page-table base, two flush registers, a fault status word and fault address, the arbiter-enable and arbitration-enable words, one configuration word per expansion slot, and a chip mask identifier. Each register keeps only its writable bits and forces some bits to one.

When a control word is written, its range field is decoded into the lowest address of the translated window. That start address goes to the translator on a dedicated output. The window always ends at the top of the 32-bit space.

The translator reports a failed translation through a one-cycle fault strobe. The strobe carries the faulting address and a flag that is set for a read. The bank records the fault and raises a level interrupt. The interrupt stays high until software reads or writes the fault status or fault address register.

Top module: `xlat_cfg_regs`

## Requirements
- R1: After reset the registers read as follows: control = {IMPL_VER, 24'h0}, fault status = 0x00800000, arbiter enable = 0x00000003, arbitration enable = 0x00000008, mask ID = 0x23000000, and every other register = 0. The window start is 0 and the interrupt is low.
- R2: A write to control (offset 0x000) keeps only the data bits selected by 0x0000001D. Bits [31:24] always read back as IMPL_VER, and all other bits read as zero.
- R3: In the cycle after a control write, the window start output equals 0xFF000000 shifted left by data bits [4:2]. Code 0 gives 16 MB and code 7 gives 2 GB. The output keeps 0 from reset until the first control write.
- R4: The page-table base (0x004) keeps the bits of mask 0x07FFFC00. Slot configuration n (0x1010 + 4n, n = 0..3) keeps the bits of mask 0x00010003. The full flush (0x014) and page flush (0x018) registers store the whole word.
- R5: The arbiter enable register (0x1008) keeps the bits of mask 0x801F000F and always has bit 0 set. The arbitration enable register (0x2000) keeps the bits of mask 0x001F0000 and always has bit 3 set.
- R6: A write to the mask ID register (0x3018) ORs (data & 0x00FFFFFF) into its contents. No write ever clears a bit.
- R7: A fault strobe loads fault status (0x1000) with 0xC0820000, or 0xC0860000 when the fault was a read. It loads fault address (0x1004) with the fault address and sets the interrupt in the next cycle.
- R8: The interrupt clears in the cycle after any of these accesses: a write to fault status (stored as data & 0xFF0FFFFF with bit 23 forced to 1), a write to fault address (stored whole), or a read of either register. A read returns the contents held before the clear.
- R9: When a fault strobe arrives in the same cycle as a clearing access, the fault wins. Status, address and interrupt all take the fault's values.
- R10: An offset that names no register, including any offset with bits [1:0] non-zero, reads as zero and ignores writes.
- R11: Read data is combinational. It shows the addressed register while select is high and write is low, and it is zero at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| flt_valid | input | 1 | One-cycle fault report from the translator |
| flt_read | input | 1 | The faulting access was a read |
| flt_addr | input | 32 | Faulting address |
| win_start | output | 32 | Lowest address of the translated window |
| irq | output | 1 | Level fault interrupt |

## Verification
The bench builds the block with IMPL_VER = 0xA5 and the default ADDR_W = 14. The non-zero version makes the forced upper byte of the control word visible, and the 14-bit offset reaches the mask ID register at the top of the map. Directed steps sweep all eight window codes, drive fault-versus-clear collisions, and issue misaligned and hole accesses. Several thousand random accesses mixed with random fault strobes then exercise every write mask and forced bit against a bench model.

// File: rtl/xlat_cfg_pkg.sv
package xlat_cfg_pkg;
  localparam int unsigned NSLOT     = 4;
  localparam int unsigned RI_CTRL   = 0;
  localparam int unsigned RI_BASE   = 1;
  localparam int unsigned RI_TFLUSH = 2;
  localparam int unsigned RI_PFLUSH = 3;
  localparam int unsigned RI_FSTAT  = 4;
  localparam int unsigned RI_FADDR  = 5;
  localparam int unsigned RI_ARB    = 6;
  localparam int unsigned RI_SLOT0  = 7;
  localparam int unsigned RI_ARBEN  = RI_SLOT0 + NSLOT;
  localparam int unsigned RI_MID    = RI_ARBEN + 1;
  localparam int unsigned NREG      = RI_MID + 1;

  localparam logic [31:0] M_CTRL   = 32'h0000_001D;
  localparam logic [31:0] M_BASE   = 32'h07FF_FC00;
  localparam logic [31:0] M_SLOT   = 32'h0001_0003;
  localparam logic [31:0] M_ARB    = 32'h801F_000F;
  localparam logic [31:0] F_ARB    = 32'h0000_0001;
  localparam logic [31:0] RST_ARB  = 32'h0000_0003;
  localparam logic [31:0] M_ARBEN  = 32'h001F_0000;
  localparam logic [31:0] F_ARBEN  = 32'h0000_0008;
  localparam logic [31:0] M_FSTAT  = 32'hFF0F_FFFF;
  localparam logic [31:0] F_FSTAT  = 32'h0080_0000;
  localparam logic [31:0] M_MID    = 32'h00FF_FFFF;
  localparam logic [31:0] RST_MID  = 32'h2300_0000;
  localparam logic [31:0] FLT_BASE = 32'hC082_0000;
  localparam logic [31:0] FLT_RD   = 32'h0004_0000;
  localparam logic [31:0] WIN_TOP  = 32'hFF00_0000;

  function automatic logic [31:0] reg_offset(int unsigned idx);
    logic [31:0] off;
    off = 32'hFFFF_FFFF;
    if (idx >= RI_SLOT0 && idx < RI_ARBEN) off = 32'h1010 + 32'((idx - RI_SLOT0) * 4);
    else if (idx == RI_CTRL)   off = 32'h0000;
    else if (idx == RI_BASE)   off = 32'h0004;
    else if (idx == RI_TFLUSH) off = 32'h0014;
    else if (idx == RI_PFLUSH) off = 32'h0018;
    else if (idx == RI_FSTAT)  off = 32'h1000;
    else if (idx == RI_FADDR)  off = 32'h1004;
    else if (idx == RI_ARB)    off = 32'h1008;
    else if (idx == RI_ARBEN)  off = 32'h2000;
    else if (idx == RI_MID)    off = 32'h3018;
    return off;
  endfunction
endpackage

// File: rtl/xlat_cfg_decode.sv
module xlat_cfg_decode
  import xlat_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr);

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr_ext == reg_offset(i));
  end
endmodule

// File: rtl/xlat_cfg_window.sv
module xlat_cfg_window
  import xlat_cfg_pkg::*;
(
  input  logic [2:0]  code,
  output logic [31:0] start
);
  assign start = WIN_TOP << code;
endmodule

// File: rtl/xlat_cfg_fault.sv
module xlat_cfg_fault
  import xlat_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flt_valid,
  input  logic        flt_read,
  input  logic [31:0] flt_addr,
  input  logic        sw_wr_stat,
  input  logic        sw_wr_addr,
  input  logic        sw_rd_clr,
  input  logic [31:0] wdata,
  output logic [31:0] stat_q,
  output logic [31:0] addr_q,
  output logic        irq_q
);
  logic [31:0] stat_d, addr_d;
  logic        irq_d;

  always_comb begin
    stat_d = stat_q;
    addr_d = addr_q;
    irq_d  = irq_q;
    if (flt_valid) begin
      stat_d = FLT_BASE | (flt_read ? FLT_RD : 32'h0);
      addr_d = flt_addr;
      irq_d  = 1'b1;
    end else begin
      if (sw_wr_stat) stat_d = (wdata & M_FSTAT) | F_FSTAT;
      if (sw_wr_addr) addr_d = wdata;
      if (sw_wr_stat || sw_wr_addr || sw_rd_clr) irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= F_FSTAT;
      addr_q <= 32'h0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      addr_q <= addr_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/xlat_cfg_regs.sv
module xlat_cfg_regs
  import xlat_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter logic [7:0]  IMPL_VER = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_valid,
  input  logic              flt_read,
  input  logic [31:0]       flt_addr,
  output logic [31:0]       win_start,
  output logic              irq
);
  localparam logic [31:0] CTRL_RST = {IMPL_VER, 24'h0};

  logic [NREG-1:0] hit, we;
  logic            wr_en, rd_en, rd_clr;
  logic [31:0]     win_calc;

  logic [31:0] ctrl_q, ctrl_d, base_q, base_d, tfl_q, tfl_d, pfl_q, pfl_d;
  logic [31:0] arb_q, arb_d, arben_q, arben_d, mid_q, mid_d, win_q, win_d;
  logic [31:0] slot_q [NSLOT];
  logic [31:0] slot_d [NSLOT];
  logic [31:0] fstat_q, faddr_q;
  logic [31:0] rd_vec [NREG];

  assign wr_en  = bus_sel & bus_wr;
  assign rd_en  = bus_sel & ~bus_wr;
  assign we     = hit & {NREG{wr_en}};
  assign rd_clr = rd_en & (hit[RI_FSTAT] | hit[RI_FADDR]);

  xlat_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .hit(hit));
  xlat_cfg_window u_win (.code(bus_wdata[4:2]), .start(win_calc));

  xlat_cfg_fault u_flt (
    .clk(clk), .rst_n(rst_n),
    .flt_valid(flt_valid), .flt_read(flt_read), .flt_addr(flt_addr),
    .sw_wr_stat(we[RI_FSTAT]), .sw_wr_addr(we[RI_FADDR]), .sw_rd_clr(rd_clr),
    .wdata(bus_wdata), .stat_q(fstat_q), .addr_q(faddr_q), .irq_q(irq)
  );

  // next-state
  always_comb begin
    ctrl_d  = ctrl_q;
    win_d   = win_q;
    base_d  = base_q;
    tfl_d   = tfl_q;
    pfl_d   = pfl_q;
    arb_d   = arb_q;
    arben_d = arben_q;
    mid_d   = mid_q;
    if (we[RI_CTRL]) begin
      ctrl_d = (bus_wdata & M_CTRL) | CTRL_RST;
      win_d  = win_calc;
    end
    if (we[RI_BASE])   base_d  = bus_wdata & M_BASE;
    if (we[RI_TFLUSH]) tfl_d   = bus_wdata;
    if (we[RI_PFLUSH]) pfl_d   = bus_wdata;
    if (we[RI_ARB])    arb_d   = (bus_wdata & M_ARB) | F_ARB;
    if (we[RI_ARBEN])  arben_d = (bus_wdata & M_ARBEN) | F_ARBEN;
    if (we[RI_MID])    mid_d   = mid_q | (bus_wdata & M_MID);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      win_q   <= 32'h0;
      base_q  <= 32'h0;
      tfl_q   <= 32'h0;
      pfl_q   <= 32'h0;
      arb_q   <= RST_ARB;
      arben_q <= F_ARBEN;
      mid_q   <= RST_MID;
    end else begin
      ctrl_q  <= ctrl_d;
      win_q   <= win_d;
      base_q  <= base_d;
      tfl_q   <= tfl_d;
      pfl_q   <= pfl_d;
      arb_q   <= arb_d;
      arben_q <= arben_d;
      mid_q   <= mid_d;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_d[s] = we[RI_SLOT0+s] ? (bus_wdata & M_SLOT) : slot_q[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[s] <= 32'h0;
      else        slot_q[s] <= slot_d[s];
    end
    assign rd_vec[RI_SLOT0+s] = slot_q[s];
  end

  assign rd_vec[RI_CTRL]   = ctrl_q;
  assign rd_vec[RI_BASE]   = base_q;
  assign rd_vec[RI_TFLUSH] = tfl_q;
  assign rd_vec[RI_PFLUSH] = pfl_q;
  assign rd_vec[RI_FSTAT]  = fstat_q;
  assign rd_vec[RI_FADDR]  = faddr_q;
  assign rd_vec[RI_ARB]    = arb_q;
  assign rd_vec[RI_ARBEN]  = arben_q;
  assign rd_vec[RI_MID]    = mid_q;

  always_comb begin
    bus_rdata = 32'h0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_en && hit[i]) bus_rdata = bus_rdata | rd_vec[i];
    end
  end

  assign win_start = win_q;
endmodule

// File: rtl/xlat_cfg_chk.sv
module xlat_cfg_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              flt_valid,
  input logic              irq,
  input logic [31:0]       win_start,
  input logic [31:0]       mid_q
);
  logic [31:0] a32;
  logic        clr_acc, rd_acc;
  assign a32     = 32'(bus_addr);
  assign rd_acc  = bus_sel && !bus_wr;
  assign clr_acc = bus_sel && (a32 == 32'h1000 || a32 == 32'h1004);

  AST_WIN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_start[23:0] == 24'h0); // R3
  AST_ARB_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && a32 == 32'h1008) |-> bus_rdata[0]); // R5
  AST_MID_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_q & $past(mid_q)) == $past(mid_q)); // R6
  AST_IRQ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> irq); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_acc && !flt_valid) |=> !irq); // R8
  AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_acc && flt_valid) |=> irq); // R9
  AST_ODD_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && a32[1:0] != 2'b00) |-> bus_rdata == 32'h0); // R10
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |-> bus_rdata == 32'h0); // R11
endmodule

bind xlat_cfg_regs xlat_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .flt_valid(flt_valid),
  .irq(irq), .win_start(win_start), .mid_q(mid_q)
);

// File: tb/xlat_cfg_regs_test.sv
`timescale 1ns/1ps
module xlat_cfg_regs_test;
  localparam logic [7:0] VER = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr, fv, fr;
  logic [13:0] addr;
  logic [31:0] wdata, fa;
  logic [31:0] rdata, win;
  logic        irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  logic [31:0] m [13];
  logic [31:0] m_win;
  logic        m_irq;

  always #2.5 clk = ~clk;

  xlat_cfg_regs #(.ADDR_W(14), .IMPL_VER(VER)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .flt_valid(fv), .flt_read(fr),
    .flt_addr(fa), .win_start(win), .irq(irq)
  );

  function automatic logic [13:0] off_of(int i);
    case (i)
      0: return 14'h0000;   1: return 14'h0004;   2: return 14'h0014;
      3: return 14'h0018;   4: return 14'h1000;   5: return 14'h1004;
      6: return 14'h1008;   7: return 14'h1010;   8: return 14'h1014;
      9: return 14'h1018;  10: return 14'h101C;  11: return 14'h2000;
      default: return 14'h3018;
    endcase
  endfunction

  function automatic int idx_of(logic [13:0] a);
    for (int i = 0; i < 13; i++) if (off_of(i) == a) return i;
    return -1;
  endfunction

  function automatic string tag_of(int i);
    case (i)
      -1: return "R10";
      0: return "R2";
      4, 5: return "R8";
      6, 11: return "R5";
      12: return "R6";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [31:0] wr_val(int i, logic [31:0] old, logic [31:0] d);
    case (i)
      0: return (d & 32'h1D) | {VER, 24'h0};
      1: return d & 32'h07FF_FC00;
      4: return (d & 32'hFF0F_FFFF) | 32'h0080_0000;
      6: return (d & 32'h801F_000F) | 32'h1;
      7, 8, 9, 10: return d & 32'h0001_0003;
      11: return (d & 32'h001F_0000) | 32'h8;
      12: return old | (d & 32'h00FF_FFFF);
      default: return d;
    endcase
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic op(bit s, bit w, logic [13:0] a, logic [31:0] d,
                    bit f, bit frd, logic [31:0] fad, string r);
    int i;
    i = idx_of(a);
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d; fv = f; fr = frd; fa = fad;
    #1;
    if (s && !w) check(r, rdata, (i < 0) ? 32'h0 : m[i]);
    else         check("R11", rdata, 32'h0);
    if (s && w && i >= 0) begin
      m[i] = wr_val(i, m[i], d);
      if (i == 0) m_win = 32'hFF00_0000 << d[4:2];
      if (i == 4 || i == 5) m_irq = 1'b0;
    end
    if (s && !w && (i == 4 || i == 5)) m_irq = 1'b0;
    if (f) begin
      m[4] = 32'hC082_0000 | (frd ? 32'h0004_0000 : 32'h0);
      m[5] = fad;
      m_irq = 1'b1;
    end
    @(posedge clk);
    #1;
    sel = 0; wr = 0; fv = 0; fr = 0;
    check("R8 irq", {31'b0, irq}, {31'b0, m_irq});
    check("R3 window", win, m_win);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; sel = 0; wr = 0; addr = 0; wdata = 0; fv = 0; fr = 0; fa = 0;
    for (int i = 0; i < 13; i++) m[i] = 32'h0;
    m[0] = {VER, 24'h0}; m[4] = 32'h0080_0000; m[6] = 32'h3;
    m[11] = 32'h8; m[12] = 32'h2300_0000;
    m_win = 32'h0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset contents
    #1;
    check("R1 window", win, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 13; i++) op(1, 0, off_of(i), 0, 0, 0, 0, "R1");

    // R2 / R3: all window codes
    for (int c = 0; c < 8; c++) begin
      op(1, 1, 14'h0000, 32'hFFFF_FFE1 | (32'(c) << 2), 0, 0, 0, "R3");
      op(1, 0, 14'h0000, 0, 0, 0, 0, "R2");
      check("R3 code", win, 32'hFF00_0000 << c);
    end

    // R4 / R5: masks and forced bits
    for (int i = 1; i < 12; i++) begin
      if (i == 4 || i == 5) continue;
      op(1, 1, off_of(i), 32'hFFFF_FFFF, 0, 0, 0, tag_of(i));
      op(1, 0, off_of(i), 0, 0, 0, 0, tag_of(i));
      op(1, 1, off_of(i), 32'h0, 0, 0, 0, tag_of(i));
      op(1, 0, off_of(i), 0, 0, 0, 0, tag_of(i));
    end

    // R6: mask ID accumulates
    op(1, 1, 14'h3018, 32'hFF00_0F0F, 0, 0, 0, "R6");
    op(1, 1, 14'h3018, 32'h0000_F000, 0, 0, 0, "R6");
    op(1, 1, 14'h3018, 32'h0, 0, 0, 0, "R6");
    op(1, 0, 14'h3018, 0, 0, 0, 0, "R6");
    check("R6 value", m[12], 32'h2300_FF0F);

    // R7: read fault capture, then read of address clears
    op(0, 0, 0, 0, 1, 1, 32'hDEAD_B000, "R7");
    op(1, 0, 14'h1000, 0, 0, 0, 0, "R7");
    check("R7 status", m[4], 32'hC086_0000);
    op(0, 0, 0, 0, 1, 0, 32'h1234_5000, "R7");
    op(1, 0, 14'h1004, 0, 0, 0, 0, "R8");
    op(0, 0, 0, 0, 1, 0, 32'h0000_1000, "R7");
    op(1, 1, 14'h1000, 32'h0, 0, 0, 0, "R8");
    op(1, 0, 14'h1000, 0, 0, 0, 0, "R8");

    // R9: fault collides with clearing accesses
    op(1, 0, 14'h1004, 0, 1, 0, 32'h0BAD_0000, "R9");
    op(1, 1, 14'h1000, 32'h0, 1, 1, 32'h0F00_0000, "R9");
    op(1, 0, 14'h1000, 0, 0, 0, 0, "R9");
    op(1, 1, 14'h1004, 32'h5555_5555, 1, 0, 32'h7777_0000, "R9");
    op(1, 0, 14'h1004, 0, 0, 0, 0, "R9");

    // R10: misaligned and hole offsets
    op(1, 1, 14'h0005, 32'hFFFF_FFFF, 0, 0, 0, "R10");
    op(1, 0, 14'h0005, 0, 0, 0, 0, "R10");
    op(1, 0, 14'h0004, 0, 0, 0, 0, "R10");
    op(1, 1, 14'h0008, 32'hFFFF_FFFF, 0, 0, 0, "R10");
    op(1, 0, 14'h0008, 0, 0, 0, 0, "R10");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [13:0] a;
      r = int'($urandom_range(0, 14));
      if (r < 13) a = off_of(r);
      else if (r == 13) begin
        case ($urandom_range(0, 3))
          0: a = 14'h0008;
          1: a = 14'h100C;
          2: a = 14'h2004;
          default: a = 14'h3FFC;
        endcase
      end else a = off_of(int'($urandom_range(0, 12))) | 14'($urandom_range(1, 3));
      op(($urandom_range(0, 5) != 0), $urandom_range(0, 1) == 1, a, $urandom(),
         $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1, $urandom(),
         tag_of(idx_of(a)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule